// File: doc/BRIEF.md
# Open-Page DRAM Command Sequencer

This block turns a stream of read requests into DRAM commands for one channel. Requests arrive one at a time on a valid/ready handshake, each with a 32-bit physical address. The block cuts the address into rank, bank, row and column fields. A per-request select input picks one of two field layouts. It keeps one open-row record for each of the sixteen rank/bank slots and emits only the commands the request needs. A row hit needs a column read alone. An idle bank needs an activate and then a read. A bank holding another row needs a precharge, an activate and then a read. All commands leave on one shared command/address bus, and a one-cycle strobe marks the cycle in which read data is due.

The three gaps between commands come from configuration inputs that are captured while reset is held. Rows stay open after a read, so a later request to the same row in the same bank costs a single command. Requests are served strictly in arrival order. A 16-bit saturating count of the commands issued so far is exported, so that the command totals of a request stream can be compared between the two layouts.

Top module: `dram_cmd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, cmd_op is NOP (0) and cmd_count is 0. All sixteen row records are empty, so the first request to any slot begins with ACT.
- R2: With cfg_layout=0 the address splits as row=addr[31:20], rank=addr[19], bank=addr[18:16], col=addr[15:0].
- R3: With cfg_layout=1 the address splits as bank=addr[31:29], rank=addr[28], row=addr[27:16], col=addr[15:0].
- R4: A request to a slot with no open row issues ACT (opcode 1), carrying rank, bank and row with col=0, in the cycle after acceptance. RD follows exactly tRCD cycles later.
- R5: A request whose row is already open in its slot issues only RD (opcode 2), carrying rank, bank and col with row=0, in the cycle after acceptance.
- R6: A request to a slot holding a different row issues PRE (opcode 3), carrying rank and bank with row=0 and col=0, in the cycle after acceptance. ACT follows tRP cycles after PRE, and RD follows tRCD cycles after ACT.
- R7: data_valid is high for exactly one cycle, tCAS cycles after each RD.
- R8: req_ready is 0 from the cycle after acceptance through the data_valid cycle, and returns to 1 in the cycle after data_valid.
- R9: In every cycle with no command, cmd_op is NOP and cmd_rank, cmd_bank, cmd_row and cmd_col are all 0.
- R10: cmd_count rises by exactly one in each cycle that shows a command and holds otherwise. It saturates at 16'hFFFF.
- R11: Each rank/bank slot keeps its own open row. Slots that differ only in rank are tracked separately, and a row left open in one slot survives traffic to other slots.
- R12: tRP, tRCD and tCAS are captured from cfg_trp, cfg_trcd and cfg_tcas while rst_n is low, with a value of 0 taken as 1. Changes to these inputs after reset have no effect on the gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; timing inputs are captured while it is low |
| cfg_trp | input | TW | Precharge-to-activate gap in cycles |
| cfg_trcd | input | TW | Activate-to-read gap in cycles |
| cfg_tcas | input | TW | Read-to-data gap in cycles |
| cfg_layout | input | 1 | Address layout for the request being accepted: 0 or 1 |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request physical address |
| req_ready | output | 1 | Block can accept a request this cycle |
| cmd_op | output | 2 | Command opcode: NOP=0, ACT=1, RD=2, PRE=3 |
| cmd_rank | output | 1 | Command rank |
| cmd_bank | output | 3 | Command bank |
| cmd_row | output | 12 | Command row (ACT only) |
| cmd_col | output | 16 | Command column (RD only) |
| data_valid | output | 1 | Read data due this cycle |
| cmd_count | output | 16 | Saturating count of issued commands |

## Verification
The in-line properties check the following on every cycle: the tRP gap before an ACT that follows a PRE, the tRCD gap before an RD that follows an ACT, and that a PRE is always followed by an ACT. They also check the one-step behaviour of the command counter, the zero fields of idle cycles, and the ready/strobe relationship. Only the bench's scenarios can show that the address fields are taken from the right bits under each layout and that the hit, empty and conflict choice matches the history of each slot. The same holds for the command totals of the two layouts, for first-command placement after acceptance, and for the timing captured at reset being kept once the configuration inputs change.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  localparam int ADDR_W = 32;
  localparam int ROW_W  = 12;
  localparam int RANK_W = 1;
  localparam int BANK_W = 3;
  localparam int COL_W  = 16;
  localparam int SLOT_W = RANK_W + BANK_W;
  localparam int NSLOT  = 1 << SLOT_W;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ACT = 2'd1,
    OP_RD  = 2'd2,
    OP_PRE = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WACT  = 3'd1,
    ST_WRD   = 3'd2,
    ST_WDATA = 3'd3,
    ST_LAST  = 3'd4
  } seq_st_e;

  typedef struct packed {
    logic [RANK_W-1:0] rank;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } loc_t;

  // layout 0: row | rank | bank | col   layout 1: bank | rank | row | col
  function automatic loc_t split_addr(input logic [ADDR_W-1:0] a, input logic lay);
    loc_t l;
    l.col = a[COL_W-1:0];
    if (!lay) begin
      l.bank = a[COL_W +: BANK_W];
      l.rank = a[COL_W+BANK_W +: RANK_W];
      l.row  = a[COL_W+BANK_W+RANK_W +: ROW_W];
    end else begin
      l.row  = a[COL_W +: ROW_W];
      l.rank = a[COL_W+ROW_W +: RANK_W];
      l.bank = a[COL_W+ROW_W+RANK_W +: BANK_W];
    end
    return l;
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input loc_t l);
    return {l.rank, l.bank};
  endfunction

  // fields a command carries on the bus; unused ones are forced to zero
  function automatic loc_t bus_fields(input op_e op, input loc_t l);
    loc_t f;
    f = '0;
    if (op != OP_NOP) begin
      f.rank = l.rank;
      f.bank = l.bank;
    end
    if (op == OP_ACT) f.row = l.row;
    if (op == OP_RD)  f.col = l.col;
    return f;
  endfunction

endpackage

// File: rtl/dcs_addr_split.sv
module dcs_addr_split
  import dcs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              layout,
  output loc_t              loc,
  output logic [SLOT_W-1:0] slot
);

  always_comb begin
    loc  = split_addr(addr, layout);
    slot = slot_of(loc);
  end

endmodule

// File: rtl/dcs_open_rows.sv
module dcs_open_rows #(
  parameter int NS  = 16,
  parameter int SW  = 4,
  parameter int RW  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] rd_slot,
  output logic          rd_open,
  output logic [RW-1:0] rd_row,
  input  logic [SW-1:0] wr_slot,
  input  logic          set_en,
  input  logic [RW-1:0] set_row,
  input  logic          clr_en
);

  logic [NS-1:0] open_q;
  logic [RW-1:0] row_q [NS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= '0;
      for (int i = 0; i < NS; i++) row_q[i] <= '0;
    end else if (set_en) begin
      open_q[wr_slot] <= 1'b1;
      row_q[wr_slot]  <= set_row;
    end else if (clr_en) begin
      open_q[wr_slot] <= 1'b0;
    end
  end

  assign rd_open = open_q[rd_slot];
  assign rd_row  = row_q[rd_slot];

  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en)); // R6

  AST_SET_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> open_q[$past(wr_slot)]); // R11

endmodule

// File: rtl/dcs_gap_timer.sv
module dcs_gap_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == TW'(1));

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0)); // R12

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dcs_pkg::*;
#(
  parameter int TW    = 4,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     cfg_trp,
  input  logic [TW-1:0]     cfg_trcd,
  input  logic [TW-1:0]     cfg_tcas,
  input  logic              cfg_layout,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic [1:0]        cmd_op,
  output logic [RANK_W-1:0] cmd_rank,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              data_valid,
  output logic [CNT_W-1:0]  cmd_count
);

  localparam int SINCE_W = TW + 1;

  function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  // timing captured during reset
  logic [TW-1:0] trp_q, trcd_q, tcas_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trp_q  <= at_least_one(cfg_trp);
      trcd_q <= at_least_one(cfg_trcd);
      tcas_q <= at_least_one(cfg_tcas);
    end
  end

  // address decode of the incoming request
  loc_t              dec_loc;
  logic [SLOT_W-1:0] dec_slot;
  dcs_addr_split u_split (
    .addr   (req_addr),
    .layout (cfg_layout),
    .loc    (dec_loc),
    .slot   (dec_slot)
  );

  seq_st_e           st_q, st_nx;
  loc_t              req_q;
  op_e               op_q;
  loc_t              bus_q;
  logic              dv_q;
  logic [CNT_W-1:0]  cnt_q;

  // open-row table
  logic              tbl_open;
  logic [ROW_W-1:0]  tbl_row;
  logic [SLOT_W-1:0] wr_slot;
  logic [ROW_W-1:0]  wr_row;
  logic              tbl_set, tbl_clr;

  dcs_open_rows #(.NS(NSLOT), .SW(SLOT_W), .RW(ROW_W)) u_rows (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_slot (dec_slot),
    .rd_open (tbl_open),
    .rd_row  (tbl_row),
    .wr_slot (wr_slot),
    .set_en  (tbl_set),
    .set_row (wr_row),
    .clr_en  (tbl_clr)
  );

  // gap timer
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  dcs_gap_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  // named events
  logic evt_accept, evt_hit, evt_empty, evt_conflict;
  assign evt_accept   = (st_q == ST_IDLE) && req_valid;
  assign evt_hit      = evt_accept && tbl_open && (tbl_row == dec_loc.row);
  assign evt_empty    = evt_accept && !tbl_open;
  assign evt_conflict = evt_accept && tbl_open && (tbl_row != dec_loc.row);

  op_e  iss_op;
  loc_t iss_loc;
  logic dv_nx;
  logic evt_issue;

  always_comb begin
    st_nx    = st_q;
    iss_op   = OP_NOP;
    iss_loc  = req_q;
    tmr_load = 1'b0;
    tmr_val  = trp_q;
    tbl_set  = 1'b0;
    tbl_clr  = 1'b0;
    wr_slot  = slot_of(req_q);
    wr_row   = req_q.row;
    dv_nx    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        iss_loc = dec_loc;
        wr_slot = dec_slot;
        wr_row  = dec_loc.row;
        if (evt_hit) begin
          iss_op   = OP_RD;
          tmr_load = 1'b1;
          tmr_val  = tcas_q;
          st_nx    = ST_WDATA;
        end else if (evt_empty) begin
          iss_op   = OP_ACT;
          tbl_set  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = trcd_q;
          st_nx    = ST_WRD;
        end else if (evt_conflict) begin
          iss_op   = OP_PRE;
          tbl_clr  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = trp_q;
          st_nx    = ST_WACT;
        end
      end
      ST_WACT: if (tmr_done) begin
        iss_op   = OP_ACT;
        tbl_set  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = trcd_q;
        st_nx    = ST_WRD;
      end
      ST_WRD: if (tmr_done) begin
        iss_op   = OP_RD;
        tmr_load = 1'b1;
        tmr_val  = tcas_q;
        st_nx    = ST_WDATA;
      end
      ST_WDATA: if (tmr_done) begin
        dv_nx = 1'b1;
        st_nx = ST_LAST;
      end
      ST_LAST: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  assign evt_issue = (iss_op != OP_NOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      req_q <= '0;
      op_q  <= OP_NOP;
      bus_q <= '0;
      dv_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_nx;
      op_q  <= iss_op;
      bus_q <= bus_fields(iss_op, iss_loc);
      dv_q  <= dv_nx;
      if (evt_accept) req_q <= dec_loc;
      if (evt_issue && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign cmd_op     = op_q;
  assign cmd_rank   = bus_q.rank;
  assign cmd_bank   = bus_q.bank;
  assign cmd_row    = bus_q.row;
  assign cmd_col    = bus_q.col;
  assign data_valid = dv_q;
  assign cmd_count  = cnt_q;

  // bus history for the gap properties
  logic [SINCE_W-1:0] since_q;
  op_e                last_op_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q   <= '0;
      last_op_q <= OP_NOP;
    end else if (op_q != OP_NOP) begin
      since_q   <= SINCE_W'(1);
      last_op_q <= op_q;
    end else if (since_q != '1) begin
      since_q   <= since_q + 1'b1;
    end
  end

  AST_PRE_ACT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_ACT && last_op_q == OP_PRE) |-> (since_q == {1'b0, trp_q})); // R6

  AST_ACT_RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_RD && last_op_q == OP_ACT) |-> (since_q == {1'b0, trcd_q})); // R4

  AST_PRE_THEN_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_NOP && last_op_q == OP_PRE) |-> (op_q == OP_ACT)); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op != OP_NOP && $past(cmd_count) != '1) |-> (cmd_count == $past(cmd_count) + 1'b1)); // R10

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_NOP) |-> $stable(cmd_count)); // R10

  AST_NOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_NOP) |-> (cmd_rank == '0 && cmd_bank == '0 && cmd_row == '0 && cmd_col == '0)); // R9

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd_op == OP_NOP && !data_valid)); // R8

  AST_READY_AFTER_DV: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> (req_ready && !data_valid)); // R7

endmodule

// File: tb/dram_cmd_seq_tb_top.sv
module dram_cmd_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_trp = 4'd3, cfg_trcd = 4'd2, cfg_tcas = 4'd4;
  logic        cfg_layout = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic [1:0]  cmd_op;
  logic [0:0]  cmd_rank;
  logic [2:0]  cmd_bank;
  logic [11:0] cmd_row;
  logic [15:0] cmd_col;
  logic        data_valid;
  logic [15:0] cmd_count;

  always #2.5 clk = ~clk;

  dram_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd),
    .cfg_tcas(cfg_tcas), .cfg_layout(cfg_layout), .req_valid(req_valid),
    .req_addr(req_addr), .req_ready(req_ready), .cmd_op(cmd_op),
    .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .data_valid(data_valid), .cmd_count(cmd_count)
  );

  typedef struct {
    int          cyc;
    logic [1:0]  op;
    logic        rank;
    logic [2:0]  bank;
    logic [11:0] row;
    logic [15:0] col;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   dv_q[$];
  int   total = 0, bad = 0;
  int   cyc = 0;
  bit   finished = 0;

  // model state
  int   m_trp, m_trcd, m_tcas;
  bit   m_open [16];
  int   m_row  [16];
  int   m_count;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push_cmd(input int c, input int op, input int rk, input int bk,
                          input int rw, input int cl, input string tag);
    exp_t e;
    e.cyc = c; e.op = 2'(op); e.rank = 1'(rk); e.bank = 3'(bk);
    e.row = 12'(rw); e.col = 16'(cl); e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compares the bus against the scoreboard away from the edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (cmd_op != 2'd0) begin
        if (exp_q.size() == 0) begin
          check(0, "R9", "unexpected command op", cmd_op, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cyc == e.cyc, e.tag, "command cycle", cyc, e.cyc);
          check(cmd_op == e.op, e.tag, "opcode", cmd_op, e.op);
          check(cmd_rank == e.rank && cmd_bank == e.bank, e.tag, "rank/bank",
                {cmd_rank, cmd_bank}, {e.rank, e.bank});
          check(cmd_row == e.row, e.tag, "row", cmd_row, e.row);
          check(cmd_col == e.col, e.tag, "col", cmd_col, e.col);
        end
      end else if (cmd_rank != 0 || cmd_bank != 0 || cmd_row != 0 || cmd_col != 0) begin
        check(0, "R9", "idle fields", {cmd_rank, cmd_bank, cmd_row, cmd_col}, 0);
      end
      if (data_valid) begin
        if (dv_q.size() == 0) check(0, "R7", "unexpected data_valid", 1, 0);
        else begin
          int d;
          d = dv_q.pop_front();
          check(cyc == d, "R7", "data_valid cycle", cyc, d);
        end
      end
    end
  end

  task automatic do_reset(input int trp, input int trcd, input int tcas);
    rst_n = 1'b0;
    cfg_trp = 4'(trp); cfg_trcd = 4'(trcd); cfg_tcas = 4'(tcas);
    m_trp  = (trp  == 0) ? 1 : trp;
    m_trcd = (trcd == 0) ? 1 : trcd;
    m_tcas = (tcas == 0) ? 1 : tcas;
    for (int i = 0; i < 16; i++) begin m_open[i] = 0; m_row[i] = 0; end
    m_count = 0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(cmd_op == 2'd0, "R1", "op after reset", cmd_op, 0);
    check(cmd_count == 16'd0, "R1", "count after reset", cmd_count, 0);
  endtask

  // driver: works out the expected sequence and feeds the request
  task automatic send(input logic [31:0] a, input bit lay, input string ftag);
    int rk, bk, rw, cl, s, acc, rd, rdy_exp;
    cl = int'(a & 32'hFFFF);
    if (!lay) begin
      rw = int'(a >> 20);
      rk = int'((a >> 19) & 1);
      bk = int'((a >> 16) & 7);
    end else begin
      bk = int'(a >> 29);
      rk = int'((a >> 28) & 1);
      rw = int'((a >> 16) & 12'hFFF);
    end
    s = rk * 8 + bk;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; cfg_layout = lay;
    acc = cyc + 1;
    if (m_open[s] && m_row[s] == rw) begin
      push_cmd(acc, 2, rk, bk, 0, cl, "R5");
      rd = acc;
      m_count += 1;
    end else if (!m_open[s]) begin
      push_cmd(acc, 1, rk, bk, rw, 0, ftag);
      push_cmd(acc + m_trcd, 2, rk, bk, 0, cl, "R4");
      rd = acc + m_trcd;
      m_count += 2;
    end else begin
      push_cmd(acc, 3, rk, bk, 0, 0, "R6");
      push_cmd(acc + m_trp, 1, rk, bk, rw, 0, ftag);
      push_cmd(acc + m_trp + m_trcd, 2, rk, bk, 0, cl, "R6");
      rd = acc + m_trp + m_trcd;
      m_count += 3;
    end
    m_open[s] = 1; m_row[s] = rw;
    dv_q.push_back(rd + m_tcas);
    rdy_exp = rd + m_tcas + 1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8", "ready drops after accept", req_ready, 0);
    while (!req_ready) @(negedge clk);
    check(cyc == rdy_exp, "R8", "ready return cycle", cyc, rdy_exp);
    check(cmd_count == 16'(m_count), "R10", "command count", cmd_count, m_count);
  endtask

  task automatic summary;
    check(exp_q.size() == 0, "R4", "leftover expected commands", exp_q.size(), 0);
    check(dv_q.size() == 0, "R7", "leftover expected strobes", dv_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    do_reset(3, 2, 4);
    // layout 0 stream: all land in rank 0 bank 0 with changing rows
    send(32'h0000_0010, 0, "R2");
    send(32'h2000_0001, 0, "R2");
    send(32'h4000_0100, 0, "R2");
    send(32'h6000_0010, 0, "R2");
    send(32'h4000_0101, 0, "R2");
    check(cmd_count == 16'd14, "R2", "layout 0 stream total", cmd_count, 14);
    send(32'h4000_0222, 0, "R5");
    check(cmd_count == 16'd15, "R5", "hit adds one command", cmd_count, 15);

    // layout 1 stream from empty rows
    do_reset(3, 2, 4);
    send(32'h0000_0010, 1, "R3");
    send(32'h2000_0001, 1, "R3");
    send(32'h4000_0100, 1, "R3");
    send(32'h6000_0010, 1, "R3");
    send(32'h4000_0101, 1, "R3");
    check(cmd_count == 16'd9, "R3", "layout 1 stream total", cmd_count, 9);
    send(32'h1ABC_0042, 1, "R3");

    // per-slot independence, rank separation
    do_reset(2, 3, 2);
    send(32'h0000_0010, 0, "R11");
    send(32'h0008_0010, 0, "R11");
    send(32'h0001_0010, 0, "R11");
    send(32'h0000_0020, 0, "R11");
    send(32'h0008_0030, 0, "R11");

    // configuration changes after reset are ignored
    cfg_trp = 4'd1; cfg_trcd = 4'd1; cfg_tcas = 4'd1;
    send(32'h0010_0000, 0, "R12");
    send(32'h0019_0007, 0, "R12");

    // zero timing clamps to one
    do_reset(0, 5, 1);
    send(32'h0000_0001, 0, "R12");
    send(32'h0030_0002, 0, "R12");
    send(32'h0030_0003, 0, "R12");

    repeat (4) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule